// File: doc/BRIEF.md
# Write-Back Data Cache Controller

This block is a direct-mapped data cache that sits between a processor and a slower memory. The processor port moves one 32-bit word per request. The memory port moves a whole 16-byte line per transfer, and each memory transfer may take several cycles. Each cache line holds a valid bit, a dirty bit, a tag and four words.

Writes that hit update only the cached copy and mark the line dirty. A miss of either kind first writes the resident line back to memory if that line is dirty. It then fetches the requested line, and the original request finishes as a hit. While a miss is being serviced the processor waits, because its ready signal stays low.

The processor raises `cpu_req_valid` with a stable command, address and write data, and holds them until it sees `cpu_ready` high for one cycle. On that cycle `cpu_rdata` carries the read result.

Top module: `wb_dcache`

## Requirements
- R1: After reset every line is invalid, so the first access to any address misses. Directly after reset both `cpu_ready` and `mem_req_valid` are low.
- R2: The address is split as follows. Bits [3:2] select the word, and word 0 is bits [31:0] of a line. Bits [1:0] are ignored. The next log2(LINES) bits form the index, and all bits above the index form the tag.
- R3: A lookup hits only when the indexed line is valid and its stored tag equals the address tag. A hit raises `cpu_ready` in the first cycle after the request is accepted and issues no memory request.
- R4: A read miss to a clean or invalid line issues exactly one memory read of the line. The requested word is then returned.
- R5: A write hit changes only the addressed word and issues no memory write. Later reads of the same line return the new word and the old contents of the other words.
- R6: A miss whose victim line is dirty first writes the whole victim line to memory at the victim's own line address. The refill read is issued only after that write completes.
- R7: A write miss fetches the line, merges the written word into it and leaves the line dirty. A later eviction writes back the merged line.
- R8: A miss whose victim line is clean issues no memory write.
- R9: `cpu_ready` is never high while a memory request is pending. It is high for exactly one cycle per request.
- R10: While `mem_req_valid` is high and `mem_ready` is low, the memory command, address and write data stay unchanged.
- R11: Every memory address is line aligned, meaning its bits [3:0] are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_we | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | 32 | Processor byte address |
| cpu_req_wdata | input | 32 | Processor write word |
| cpu_rdata | output | 32 | Read word, valid while cpu_ready is high |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_req_valid | output | 1 | Memory request pending |
| mem_req_we | output | 1 | 1 = line write-back, 0 = line fetch |
| mem_req_addr | output | 32 | Line-aligned memory address |
| mem_req_wdata | output | 128 | Line being written back |
| mem_rdata | input | 128 | Fetched line, valid while mem_ready is high |
| mem_ready | input | 1 | Memory transfer complete |

## Verification
The hardest situation to reach from the ports is a miss that evicts a dirty line. The same index must first be filled, then dirtied by a write hit or a write miss, and only then hit with a different tag. The bench builds exactly that sequence on two indices. It uses a memory model with a fixed multi-cycle delay and records when each read and each write completes. From those records the bench checks that the write-back came first, went to the victim's address and carried the merged data.

// File: rtl/wb_dcache_pkg.sv
package wb_dcache_pkg;

    localparam int ADDR_W     = 32;
    localparam int WORD_W     = 32;
    localparam int LINE_WORDS = 4;
    localparam int LINE_W     = WORD_W * LINE_WORDS;
    localparam int OFF_W      = 4;
    localparam int WSEL_W     = 2;
    localparam int BSEL_W     = 2;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COMPARE = 2'd1,
        ST_EVICT   = 2'd2,
        ST_REFILL  = 2'd3
    } wbc_state_e;

    typedef struct packed {
        logic                       we;
        logic [ADDR_W-1:BSEL_W]     waddr;
        logic [WORD_W-1:0]          wdata;
    } wbc_req_t;

    function automatic logic [WORD_W-1:0] line_get_word(
        input logic [LINE_W-1:0] line,
        input logic [WSEL_W-1:0] sel
    );
        return line[sel*WORD_W +: WORD_W];
    endfunction

    function automatic logic [LINE_W-1:0] line_put_word(
        input logic [LINE_W-1:0] line,
        input logic [WSEL_W-1:0] sel,
        input logic [WORD_W-1:0] word
    );
        logic [LINE_W-1:0] r;
        r = line;
        r[sel*WORD_W +: WORD_W] = word;
        return r;
    endfunction

endpackage

// File: rtl/wb_dcache_tags.sv
module wb_dcache_tags #(
    parameter int LINES = 16,
    parameter int TAG_W = 24,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic             rd_dirty,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_dirty,
    input  logic [TAG_W-1:0] wr_tag
);
    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_entry
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q[g] <= 1'b0;
                dirty_q[g] <= 1'b0;
            end else if (sel) begin
                valid_q[g] <= 1'b1;
                dirty_q[g] <= wr_dirty;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                tag_q[g] <= wr_tag;
            end
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];

endmodule

// File: rtl/wb_dcache_data.sv
module wb_dcache_data
    import wb_dcache_pkg::*;
#(
    parameter int LINES = 16,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [LINE_W-1:0] wr_line
);
    logic [LINE_W-1:0] line_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IDX_W'(g))) begin
                line_q[g] <= wr_line;
            end
        end
    end

    assign rd_line = line_q[rd_idx];

endmodule

// File: rtl/wb_dcache_ctrl.sv
module wb_dcache_ctrl
    import wb_dcache_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cpu_req_valid,
    input  logic       lookup_hit,
    input  logic       victim_dirty,
    input  logic       mem_ready,
    output wbc_state_e state,
    output logic       capture,
    output logic       done,
    output logic       fill,
    output logic       mem_valid,
    output logic       mem_we
);
    wbc_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (cpu_req_valid) state_d = ST_COMPARE;
            ST_COMPARE: begin
                if (lookup_hit)        state_d = ST_IDLE;
                else if (victim_dirty) state_d = ST_EVICT;
                else                   state_d = ST_REFILL;
            end
            ST_EVICT:   if (mem_ready) state_d = ST_REFILL;
            ST_REFILL:  if (mem_ready) state_d = ST_COMPARE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign state     = state_q;
    assign capture   = (state_q == ST_IDLE) && cpu_req_valid;
    assign done      = (state_q == ST_COMPARE) && lookup_hit;
    assign mem_valid = (state_q == ST_EVICT) || (state_q == ST_REFILL);
    assign mem_we    = (state_q == ST_EVICT);
    assign fill      = (state_q == ST_REFILL) && mem_ready;

endmodule

// File: rtl/wb_dcache.sv
module wb_dcache
    import wb_dcache_pkg::*;
#(
    parameter int LINES = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_req_valid,
    input  logic          cpu_req_we,
    input  logic [31:0]   cpu_req_addr,
    input  logic [31:0]   cpu_req_wdata,
    output logic [31:0]   cpu_rdata,
    output logic          cpu_ready,
    output logic          mem_req_valid,
    output logic          mem_req_we,
    output logic [31:0]   mem_req_addr,
    output logic [127:0]  mem_req_wdata,
    input  logic [127:0]  mem_rdata,
    input  logic          mem_ready
);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

    wbc_req_t          req_q;
    wbc_state_e        state;
    logic              capture, done, fill;
    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tag;
    logic [WSEL_W-1:0] wsel;
    logic              rd_valid, rd_dirty;
    logic [TAG_W-1:0]  rd_tag;
    logic [LINE_W-1:0] rd_line;
    logic              lookup_hit;
    logic              write_hit;
    logic              tag_wr, data_wr;
    logic [LINE_W-1:0] data_wr_line;
    logic              byte_sel_unused;

    assign byte_sel_unused = ^cpu_req_addr[BSEL_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else if (capture) begin
            req_q.we    <= cpu_req_we;
            req_q.waddr <= cpu_req_addr[ADDR_W-1:BSEL_W];
            req_q.wdata <= cpu_req_wdata;
        end
    end

    assign wsel = req_q.waddr[OFF_W-1:BSEL_W];
    assign idx  = req_q.waddr[OFF_W +: IDX_W];
    assign tag  = req_q.waddr[ADDR_W-1 -: TAG_W];

    assign lookup_hit = rd_valid && (rd_tag == tag);
    assign write_hit  = done && req_q.we;

    wb_dcache_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .cpu_req_valid (cpu_req_valid),
        .lookup_hit    (lookup_hit),
        .victim_dirty  (rd_valid && rd_dirty),
        .mem_ready     (mem_ready),
        .state         (state),
        .capture       (capture),
        .done          (done),
        .fill          (fill),
        .mem_valid     (mem_req_valid),
        .mem_we        (mem_req_we)
    );

    assign tag_wr       = fill || write_hit;
    assign data_wr      = fill || write_hit;
    assign data_wr_line = fill ? mem_rdata
                               : line_put_word(rd_line, wsel, req_q.wdata);

    wb_dcache_tags #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (idx),
        .rd_valid (rd_valid),
        .rd_dirty (rd_dirty),
        .rd_tag   (rd_tag),
        .wr_en    (tag_wr),
        .wr_idx   (idx),
        .wr_dirty (write_hit),
        .wr_tag   (tag)
    );

    wb_dcache_data #(.LINES(LINES)) u_data (
        .clk     (clk),
        .rd_idx  (idx),
        .rd_line (rd_line),
        .wr_en   (data_wr),
        .wr_idx  (idx),
        .wr_line (data_wr_line)
    );

    assign cpu_ready     = done;
    assign cpu_rdata     = line_get_word(rd_line, wsel);
    assign mem_req_addr  = (state == ST_EVICT) ? {rd_tag, idx, {OFF_W{1'b0}}}
                                               : {tag, idx, {OFF_W{1'b0}}};
    assign mem_req_wdata = rd_line;

endmodule

// File: rtl/wb_dcache_chk.sv
module wb_dcache_chk (
    input logic          clk,
    input logic          rst,
    input logic          cpu_ready,
    input logic          mem_req_valid,
    input logic          mem_req_we,
    input logic [31:0]   mem_req_addr,
    input logic [127:0]  mem_req_wdata,
    input logic          mem_ready
);
    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!cpu_ready && !mem_req_valid));

    p_evict_then_fill_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_we && mem_ready) |=> (mem_req_valid && !mem_req_we));

    p_stall_r9: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> !mem_req_valid);

    p_ready_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |=> !cpu_ready);

    p_mem_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_ready) |=>
            (mem_req_valid && $stable(mem_req_we) && $stable(mem_req_addr)
             && $stable(mem_req_wdata)));

    p_line_aligned_r11: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (mem_req_addr[3:0] == 4'h0));

endmodule

bind wb_dcache wb_dcache_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .cpu_ready     (cpu_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_ready     (mem_ready)
);

// File: tb/tb_wb_dcache.sv
module tb_wb_dcache;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_LAT    = 3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cpu_req_valid = 1'b0;
    logic         cpu_req_we = 1'b0;
    logic [31:0]  cpu_req_addr = '0;
    logic [31:0]  cpu_req_wdata = '0;
    logic [31:0]  cpu_rdata;
    logic         cpu_ready;
    logic         mem_req_valid, mem_req_we;
    logic [31:0]  mem_req_addr;
    logic [127:0] mem_req_wdata;
    logic [127:0] mem_rdata;
    logic         mem_ready;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wb_dcache dut (
        .clk(clk), .rst(rst),
        .cpu_req_valid(cpu_req_valid), .cpu_req_we(cpu_req_we),
        .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    // ---------------- memory model ----------------
    logic [127:0] mem [256];
    int    n_rd = 0, n_wr = 0, lat_cnt = 0, cyc = 0;
    int    rd_stamp = 0, wr_stamp = 0;
    logic [31:0] last_rd_addr = '0, last_wr_addr = '0, held_addr = '0;
    int    hold_viol = 0, stall_viol = 0;

    function automatic logic [31:0] iw(input int line, input int w);
        return 32'hC0DE_0000 ^ 32'(line << 8) ^ 32'(w);
    endfunction

    initial begin
        for (int l = 0; l < 256; l++)
            for (int w = 0; w < 4; w++)
                mem[l][w*32 +: 32] = iw(l, w);
    end

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        if (rst) begin
            mem_ready <= 1'b0;
            mem_rdata <= '0;
            lat_cnt   <= 0;
        end else if (mem_ready) begin
            mem_ready <= 1'b0;
            lat_cnt   <= 0;
        end else if (mem_req_valid) begin
            if (lat_cnt == 0) held_addr <= mem_req_addr;
            else if (held_addr != mem_req_addr) hold_viol <= hold_viol + 1;
            if (lat_cnt == MEM_LAT - 1) begin
                mem_ready <= 1'b1;
                lat_cnt   <= 0;
                if (mem_req_we) begin
                    mem[mem_req_addr[11:4]] <= mem_req_wdata;
                    n_wr         <= n_wr + 1;
                    wr_stamp     <= cyc;
                    last_wr_addr <= mem_req_addr;
                end else begin
                    mem_rdata    <= mem[mem_req_addr[11:4]];
                    n_rd         <= n_rd + 1;
                    rd_stamp     <= cyc;
                    last_rd_addr <= mem_req_addr;
                end
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end
    end

    always @(negedge clk) if (!rst && cpu_ready && mem_req_valid) stall_viol++;

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [31:0] a, input logic [31:0] d,
                          output logic [31:0] q, output int ncyc);
        bit got = 0;
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_we = we; cpu_req_addr = a; cpu_req_wdata = d;
        ncyc = 0; q = '0;
        for (int i = 0; i < 500 && !got; i++) begin
            @(negedge clk);
            ncyc++;
            if (cpu_ready) begin q = cpu_rdata; got = 1; end
        end
        cpu_req_valid = 1'b0;
        check(got, "R9", "request completed", 128'(got), 128'd1);
        @(negedge clk);
        check(!cpu_ready, "R9", "ready is a single pulse", 128'(cpu_ready), 128'd0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        check(!cpu_ready && !mem_req_valid, "R1", "idle after reset",
              128'({cpu_ready, mem_req_valid}), 128'd0);
    endtask

    task automatic t_read_miss();
        logic [31:0] q; int c; int r0 = n_rd, w0 = n_wr;
        access(1'b0, 32'h0000_0014, '0, q, c);
        check(q == iw(1, 1), "R4", "read miss data", 128'(q), 128'(iw(1, 1)));
        check(n_rd - r0 == 1 && n_wr == w0, "R1", "cold miss reads once",
              128'(n_rd - r0), 128'd1);
        check(last_rd_addr == 32'h10, "R11", "aligned fill address",
              128'(last_rd_addr), 128'h10);
    endtask

    task automatic t_read_hit();
        logic [31:0] q; int c; int r0 = n_rd;
        access(1'b0, 32'h0000_001B, '0, q, c);
        check(q == iw(1, 2), "R2", "word select ignores byte bits", 128'(q), 128'(iw(1, 2)));
        check(c == 1 && n_rd == r0, "R3", "hit latency and no memory access",
              128'(c), 128'd1);
    endtask

    task automatic t_write_hit();
        logic [31:0] q; int c; int w0 = n_wr;
        access(1'b1, 32'h0000_0014, 32'hDEAD_BEEF, q, c);
        check(c == 1 && n_wr == w0, "R5", "write hit stays in cache", 128'(n_wr - w0), 128'd0);
        access(1'b0, 32'h0000_0014, '0, q, c);
        check(q == 32'hDEAD_BEEF, "R5", "updated word", 128'(q), 128'hDEAD_BEEF);
        access(1'b0, 32'h0000_0010, '0, q, c);
        check(q == iw(1, 0), "R5", "neighbour word kept", 128'(q), 128'(iw(1, 0)));
    endtask

    task automatic t_dirty_evict();
        logic [31:0] q; int c; int r0 = n_rd, w0 = n_wr;
        access(1'b0, 32'h0000_0114, '0, q, c);
        check(q == iw(17, 1), "R6", "data after eviction", 128'(q), 128'(iw(17, 1)));
        check(n_wr - w0 == 1 && n_rd - r0 == 1, "R6", "one write-back one fill",
              128'({16'(n_wr - w0), 16'(n_rd - r0)}), 128'h0001_0001);
        check(last_wr_addr == 32'h10, "R6", "victim address", 128'(last_wr_addr), 128'h10);
        check(wr_stamp < rd_stamp, "R6", "write-back before fill",
              128'(wr_stamp), 128'(rd_stamp));
        check(mem[1][63:32] == 32'hDEAD_BEEF && mem[1][31:0] == iw(1, 0), "R6",
              "written-back line", mem[1], {iw(1, 3), iw(1, 2), 32'hDEAD_BEEF, iw(1, 0)});
    endtask

    task automatic t_clean_evict();
        logic [31:0] q; int c; int r0 = n_rd, w0 = n_wr;
        access(1'b0, 32'h0000_0214, '0, q, c);
        check(q == iw(33, 1), "R8", "data after clean replace", 128'(q), 128'(iw(33, 1)));
        check(n_wr == w0 && n_rd - r0 == 1, "R8", "no write-back of clean line",
              128'(n_wr - w0), 128'd0);
    endtask

    task automatic t_write_miss();
        logic [31:0] q; int c; int r0 = n_rd, w0 = n_wr;
        access(1'b1, 32'h0000_0038, 32'h1234_5678, q, c);
        check(c > 1 && n_rd - r0 == 1 && n_wr == w0, "R7", "write miss fetches line",
              128'(n_rd - r0), 128'd1);
        access(1'b0, 32'h0000_0038, '0, q, c);
        check(q == 32'h1234_5678 && c == 1, "R7", "merged word hits", 128'(q), 128'h1234_5678);
        access(1'b0, 32'h0000_0034, '0, q, c);
        check(q == iw(3, 1), "R7", "fetched word kept", 128'(q), 128'(iw(3, 1)));
        w0 = n_wr;
        access(1'b0, 32'h0000_0138, '0, q, c);
        check(n_wr - w0 == 1 && last_wr_addr == 32'h30, "R7", "merged line is dirty",
              128'(last_wr_addr), 128'h30);
        check(mem[3][95:64] == 32'h1234_5678 && mem[3][63:32] == iw(3, 1), "R7",
              "merged line in memory", mem[3], {iw(3, 3), 32'h1234_5678, iw(3, 1), iw(3, 0)});
    endtask

    task automatic t_all_indices();
        logic [31:0] q; int c; int w0 = n_wr; int bad = 0;
        for (int i = 0; i < 16; i++) access(1'b0, 32'h400 + 32'(i * 16), '0, q, c);
        for (int i = 0; i < 16; i++) begin
            access(1'b0, 32'h40C + 32'(i * 16), '0, q, c);
            if (c != 1 || q != iw(64 + i, 3)) bad++;
        end
        check(bad == 0, "R3", "every index hits after fill", 128'(bad), 128'd0);
        check(n_wr == w0, "R8", "clean lines never written", 128'(n_wr - w0), 128'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_read_miss();
        t_read_hit();
        t_write_hit();
        t_dirty_evict();
        t_clean_evict();
        t_write_miss();
        t_all_indices();
        check(stall_viol == 0, "R9", "no ready during memory request", 128'(stall_viol), 128'd0);
        check(hold_viol == 0, "R10", "memory request held", 128'(hold_viol), 128'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule